// File: doc/BRIEF.md
# Banked RAM Card Soft-Switch Controller

This block holds the control state for a 128 KB expansion memory card built from eight 16 KB blocks, where each block acts as a bank-switched language card. The host touches one of sixteen switch offsets. The block decodes the access and updates four control outputs, which an external memory mapper uses:

- whether reads come from RAM or from ROM,
- whether RAM writes are allowed,
- which of the two 4 KB banks is selected,
- which 16 KB block is active.

Half of the offsets change the read and write mode together with the bank. The other half only pick a block. Writes are armed by a saturating counter. Writes are allowed only while that counter sits at its enabled level. Starting from the disabled state, two successive arming accesses are therefore needed. The RAM array, the ROM and the address translation live outside this block.

Top module: `bankcard_switch`

## Requirements
- R1: After reset, rd_ram is 0, wr_en is 1, alt_bank is 1 and block is 0.
- R2: An access to a mode offset (offset bit 2 = 0) sets rd_ram to 1 when offset bits [1:0] are 00 or 11, and to 0 when they are 01 or 10.
- R3: An access to a mode offset sets alt_bank to offset bit 3.
- R4: An access to a disabling offset (bit 2 = 0 and bit 0 = 0, that is 0x0, 0x2, 0x8, 0xA) clears the arming counter, so wr_en is 0 after it.
- R5: An access to an arming offset (bit 2 = 0 and bit 0 = 1, that is 0x1, 0x3, 0x9, 0xB) adds one to the arming counter, which saturates at 2. wr_en is 1 only while the counter equals 2. From the disabled state, one arming access leaves wr_en at 0, a second sets it to 1, and a third keeps it at 1.
- R6: An access to a block offset (bit 2 = 1) sets block to {offset bit 3, offset bits [1:0]}. Offsets 0x4–0x7 select blocks 0–3 and offsets 0xC–0xF select blocks 4–7.
- R7: A block offset leaves rd_ram, wr_en, alt_bank and the arming counter unchanged.
- R8: The read/write flag has no effect: a read and a write to the same offset perform the same action.
- R9: Outputs change only on the clock edge that samples an asserted strobe. Without a strobe, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_strobe | input | 1 | One-cycle pulse marking a switch access |
| sw_write | input | 1 | Access direction flag (ignored by the decode) |
| sw_off | input | 4 | Switch offset within the 16-entry window |
| rd_ram | output | 1 | 1: reads served from RAM, 0: from ROM |
| wr_en | output | 1 | RAM writes allowed |
| alt_bank | output | 1 | Alternate 4 KB bank selected |
| block | output | 3 | Active 16 KB block |

## Verification
The hardest state to reach is a partly armed counter that must survive an unrelated access. The stimulus first disables writes and then arms once. It then selects a block, and arms once more. wr_en must rise on that second arming access only if the block select left the counter alone. The full arming sequence also mixes read and write accesses, so the second, enabling access is a write. This shows that the direction flag does not disturb the count.

// File: rtl/bankcard_switch.sv
module bankcard_switch #(
  parameter int ARM_LEVEL = 2,
  localparam int CW = $clog2(ARM_LEVEL + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_strobe,
  input  logic       sw_write,
  input  logic [3:0] sw_off,
  output logic       rd_ram,
  output logic       wr_en,
  output logic       alt_bank,
  output logic [2:0] block
);

  logic [CW-1:0] arm_cnt;
  logic          mode_hit, arm_hit;

  assign mode_hit = sw_strobe & ~sw_off[2];
  assign arm_hit  = sw_off[0];
  assign wr_en    = (arm_cnt == CW'(ARM_LEVEL));

  logic unused_dir;
  assign unused_dir = sw_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ram   <= 1'b0;
      alt_bank <= 1'b1;
      arm_cnt  <= CW'(ARM_LEVEL);
      block    <= '0;
    end else if (sw_strobe) begin
      if (mode_hit) begin
        rd_ram   <= ~(sw_off[0] ^ sw_off[1]);
        alt_bank <= sw_off[3];
        if (!arm_hit)
          arm_cnt <= '0;
        else if (arm_cnt != CW'(ARM_LEVEL))
          arm_cnt <= arm_cnt + 1'b1;
      end else begin
        block <= {sw_off[3], sw_off[1:0]};
      end
    end
  end

endmodule

module bankcard_switch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_strobe,
  input logic [3:0] sw_off,
  input logic       rd_ram,
  input logic       wr_en,
  input logic       alt_bank,
  input logic [2:0] block
);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_strobe |=> $stable({rd_ram, wr_en, alt_bank, block}));

  p_disable_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_strobe && !sw_off[2] && !sw_off[0]) |=> !wr_en);

  p_mode_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_strobe && !sw_off[2]) |=> rd_ram == ($past(sw_off[0]) == $past(sw_off[1])));

  p_mode_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_strobe && !sw_off[2]) |=> alt_bank == $past(sw_off[3]));

  p_block_pick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_strobe && sw_off[2]) |=> block == {$past(sw_off[3]), $past(sw_off[1:0])});

  p_block_keeps_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_strobe && sw_off[2]) |=> $stable({rd_ram, wr_en, alt_bank}));

  p_rise_needs_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> $past(sw_strobe && !sw_off[2] && sw_off[0]));

endmodule

bind bankcard_switch bankcard_switch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_strobe(sw_strobe), .sw_off(sw_off),
  .rd_ram(rd_ram), .wr_en(wr_en), .alt_bank(alt_bank), .block(block)
);

// File: tb/bankcard_switch_tb.sv
`timescale 1ns/1ps
module bankcard_switch_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_strobe = 1'b0;
  logic sw_write = 1'b0;
  logic [3:0] sw_off = '0;
  logic rd_ram, wr_en, alt_bank;
  logic [2:0] block;

  always #2.5 clk = ~clk;

  bankcard_switch u_dut (
    .clk(clk), .rst_n(rst_n), .sw_strobe(sw_strobe), .sw_write(sw_write),
    .sw_off(sw_off), .rd_ram(rd_ram), .wr_en(wr_en), .alt_bank(alt_bank),
    .block(block)
  );

  typedef struct {
    logic [5:0] exp;
    string      tag;
  } item_t;

  item_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  int m_cnt = 2;
  logic m_rd = 0, m_alt = 1;
  logic [2:0] m_blk = 0;

  function automatic logic [5:0] model_out();
    return {m_rd, (m_cnt == 2), m_alt, m_blk};
  endfunction

  task automatic compare(logic [5:0] exp, string tag);
    logic [5:0] act;
    act = {rd_ram, wr_en, alt_bank, block};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got {rd,wr,alt,blk}=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic access(input logic [3:0] off, input logic wr, input string tag);
    item_t it;
    @(negedge clk);
    sw_strobe = 1'b1; sw_off = off; sw_write = wr;
    if (!off[2]) begin
      m_rd  = (off[0] == off[1]);
      m_alt = off[3];
      if (!off[0]) m_cnt = 0;
      else if (m_cnt < 2) m_cnt++;
    end else begin
      m_blk = {off[3], off[1:0]};
    end
    it.exp = model_out(); it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    sw_strobe = 1'b0;
  endtask

  task automatic idle(input logic [3:0] off, input string tag);
    item_t it;
    @(negedge clk);
    sw_strobe = 1'b0; sw_off = off; sw_write = 1'b1;
    it.exp = model_out(); it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        compare(it.exp, it.tag);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare(6'b0_1_1_000, "R1 reset state");

    access(4'h2, 0, "R4 disable from reset, R2 ROM");
    access(4'h1, 0, "R5 first arm stays low");
    access(4'h1, 1, "R5 second arm enables, R8 write flag");
    access(4'h3, 0, "R5 third arm stays high, R2 RAM");
    access(4'h8, 1, "R4 alt disable, R3 alt bank, R2 RAM");
    access(4'hB, 0, "R5 one arm after disable");
    access(4'hD, 1, "R6 block 5, R7 mode kept");
    access(4'h9, 0, "R7 counter kept across block select");
    idle(4'h0, "R9 no strobe hold");
    idle(4'h4, "R9 no strobe hold");
    idle(4'h2, "R9 no strobe hold");
    for (int i = 0; i < 8; i++) begin
      logic [3:0] o;
      o = {i[2], 1'b1, i[1:0]};
      access(o, i[0], "R6 block select sweep");
    end
    access(4'hA, 0, "R4 disable via 0xA, R3 alt");
    access(4'h0, 1, "R8 write to 0x0, R2 RAM, R3 primary");
    access(4'h3, 1, "R5 arm once from 0 via write");
    access(4'h3, 0, "R5 arm twice enables");
    access(4'h6, 0, "R7 block keeps enabled write");
    access(4'h2, 1, "R4 disable clears enabled counter");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule